// File: doc/BRIEF.md
# Synchronous Charge-Balance Pulse Modulator

This block is a digital model of a synchronous voltage-to-frequency converter. Four unsigned sample channels stand in for analog input levels. A two-bit pair select forms one difference from them, and that difference is scaled by a gain of one or two. The result is then mapped, in unipolar or bipolar mode, onto a position within the reference span. An accumulator adds a rate increment on every clock. Whenever the sum reaches a fixed quantum, the loop subtracts that quantum and emits a single-clock pulse. The average pulse rate therefore runs linearly from 5% of the clock at zero scale up to 45% at full scale.

Downstream logic counts the pulses over a gate window that is derived from the same clock, so only the ratio of pulse rate to clock rate carries information. An active-low power-down input silences the output. After power-down is released, the output stays quiet for a settling interval before the loop runs again. A change on the inputs passes through the same number of delay stages before it reaches the loop.

Top module: `vfc_pulse_mod`

## Requirements
- R1: Let p be the normalized position of the input in [0,1]. Over any run of N clocks with steady inputs, the pulse count is within one pulse of N*(1+8p)/20. That is 0.05 of the clock at p=0 and 0.45 at p=1.
- R2: In unipolar mode with gain 1 and REF_CODE=2048, fixed difference values give fixed pulse spacings. A difference of 1024 (half scale) gives a pulse on every 4th clock. A difference of 256 (one eighth) gives a pulse on every 10th clock. A difference of 512 (one quarter) gives spacings of only 6 or 7 clocks.
- R3: Every pulse is exactly one clock high, and two pulses are never on consecutive clocks.
- R4: pair_sel chooses the difference as follows: 2'b00 is smp_0 minus smp_3, 2'b01 is smp_1 minus smp_3, 2'b10 is smp_2 minus smp_3, and 2'b11 is smp_0 minus smp_1.
- R5: Let d be the difference and G the gain (2 when gain_x2 is 1, otherwise 1). In unipolar mode (bipolar_en=0), p = d*G/REF_CODE. In bipolar mode (bipolar_en=1), p = (d*G+REF_CODE)/(2*REF_CODE).
- R6: A value of p below 0 saturates at the 0.05 rate, and a value of p above 1 saturates at the 0.45 rate.
- R7: While pd_n is low, pulse_o is low from the first clock edge at which pd_n is sampled low.
- R8: After pd_n returns high, no pulse appears for SETTLE_CYC clock edges, and the loop then restarts from an empty accumulator. An input change reaches the loop after 1+SETTLE_CYC register stages.
- R9: While rst_n is low, pulse_o is low and the loop state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| smp_0 | input | SMP_W | Sample channel 0 |
| smp_1 | input | SMP_W | Sample channel 1 |
| smp_2 | input | SMP_W | Sample channel 2 |
| smp_3 | input | SMP_W | Sample channel 3, common reference of the pseudo-differential pairs |
| pair_sel | input | 2 | Difference pair select |
| bipolar_en | input | 1 | 1 selects bipolar mapping, 0 selects unipolar |
| gain_x2 | input | 1 | 1 selects a front-end gain of 2 |
| pulse_o | output | 1 | Single-clock output pulse train |

## Verification
The assertions assume that inputs change only between clock edges and that the parameters satisfy 20*2*REF_CODE < 2^ACC_W. Under those conditions the registered increment always lies between the zero-scale and full-scale values, so the accumulator stays below one quantum. The stimulus drives every input on the falling clock edge and draws sample values across the full SMP_W range. Many of the random points therefore fall outside the selected range and exercise saturation. The bench also waits out the input latency before it opens a counting window.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  typedef enum logic [1:0] {
    PAIR_0_3 = 2'b00,
    PAIR_1_3 = 2'b01,
    PAIR_2_3 = 2'b10,
    PAIR_0_1 = 2'b11
  } pair_sel_e;
endpackage

// File: rtl/vfc_front.sv
// Pair select, gain, range mapping and clamp; registered rate increment.
module vfc_front
  import vfc_pkg::*;
#(
  parameter int SMP_W    = 12,
  parameter int REF_CODE = 2048,
  parameter int ACC_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp_0,
  input  logic [SMP_W-1:0] smp_1,
  input  logic [SMP_W-1:0] smp_2,
  input  logic [SMP_W-1:0] smp_3,
  input  logic [1:0]       pair_sel,
  input  logic             bipolar_en,
  input  logic             gain_x2,
  output logic [ACC_W-1:0] inc_o
);
  localparam int SPAN = 2 * REF_CODE;
  localparam logic signed [ACC_W-1:0] SPAN_S = ACC_W'(SPAN);
  localparam logic signed [ACC_W-1:0] REF_S  = ACC_W'(REF_CODE);

  logic [SMP_W-1:0]        pos_c, neg_c;
  logic signed [ACC_W-1:0] diff_c, scaled_c, pos2_c, clip_c;
  logic [ACC_W-1:0]        inc_c, inc_q;

  always_comb begin
    unique case (pair_sel_e'(pair_sel))
      PAIR_0_3: begin pos_c = smp_0; neg_c = smp_3; end
      PAIR_1_3: begin pos_c = smp_1; neg_c = smp_3; end
      PAIR_2_3: begin pos_c = smp_2; neg_c = smp_3; end
      default:  begin pos_c = smp_0; neg_c = smp_1; end
    endcase
    diff_c   = $signed({{(ACC_W-SMP_W){1'b0}}, pos_c})
             - $signed({{(ACC_W-SMP_W){1'b0}}, neg_c});
    scaled_c = gain_x2 ? (diff_c <<< 1) : diff_c;
    // position on a 0..SPAN scale (twice the reference resolution)
    pos2_c   = bipolar_en ? (scaled_c + REF_S) : (scaled_c <<< 1);
    if (pos2_c < 0)           clip_c = '0;
    else if (pos2_c > SPAN_S) clip_c = SPAN_S;
    else                      clip_c = pos2_c;
    inc_c    = ACC_W'(SPAN) + (ACC_W'(clip_c) << 3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inc_q <= ACC_W'(SPAN);
    else        inc_q <= inc_c;
  end

  assign inc_o = inc_q;

  // R6: the registered increment never leaves the 0.05..0.45 window
  p_inc_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q >= ACC_W'(SPAN)) && (inc_q <= ACC_W'(9 * SPAN)));
endmodule

// File: rtl/vfc_delay.sv
// Settling delay line for the increment.
module vfc_delay #(
  parameter int ACC_W      = 24,
  parameter int STAGES     = 2,
  parameter int RESET_CODE = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] d_i,
  output logic [ACC_W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_line
      logic [ACC_W-1:0] stage_q [STAGES];
      logic [ACC_W-1:0] stage_n [STAGES];
      always_comb begin
        stage_n[0] = d_i;
        for (int i = 1; i < STAGES; i++) stage_n[i] = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= ACC_W'(RESET_CODE);
        end else begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_n[i];
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/vfc_loop.sv
// Charge-balance accumulator, pulse decision and settle blanking.
module vfc_loop #(
  parameter int ACC_W      = 24,
  parameter int QUANTUM    = 81920,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [ACC_W-1:0] inc_i,
  output logic             pulse_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 2);
  localparam logic [ACC_W-1:0] Q_C = ACC_W'(QUANTUM);

  logic [ACC_W-1:0] acc_q, acc_n, sum_c;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pulse_q, pulse_n, fire_c;

  always_comb begin
    sum_c  = acc_q + inc_i;
    fire_c = (sum_c >= Q_C);
    if (!pd_n) begin
      cnt_n = CNT_W'(SETTLE_CYC);
      acc_n = '0;
      pulse_n = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
      acc_n = '0;
      pulse_n = 1'b0;
    end else begin
      cnt_n = cnt_q;
      acc_n = fire_c ? (sum_c - Q_C) : sum_c;
      pulse_n = fire_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= acc_n;
      cnt_q   <= cnt_n;
      pulse_q <= pulse_n;
    end
  end

  assign pulse_o = pulse_q;

  // R1: residual charge stays below one quantum
  p_acc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < Q_C);
  // R3: a pulse is followed by a low clock
  p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R8: settle blanking keeps the output quiet
  p_settle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> !pulse_q);
endmodule

// File: rtl/vfc_pulse_mod.sv
module vfc_pulse_mod #(
  parameter int SMP_W      = 12,
  parameter int REF_CODE   = 2048,
  parameter int ACC_W      = 24,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [SMP_W-1:0] smp_0,
  input  logic [SMP_W-1:0] smp_1,
  input  logic [SMP_W-1:0] smp_2,
  input  logic [SMP_W-1:0] smp_3,
  input  logic [1:0]       pair_sel,
  input  logic             bipolar_en,
  input  logic             gain_x2,
  output logic             pulse_o
);
  localparam int SPAN    = 2 * REF_CODE;
  localparam int QUANTUM = 20 * SPAN;

  logic [ACC_W-1:0] inc_f, inc_d;

  vfc_front #(.SMP_W(SMP_W), .REF_CODE(REF_CODE), .ACC_W(ACC_W)) u_front (
    .clk(clk), .rst_n(rst_n),
    .smp_0(smp_0), .smp_1(smp_1), .smp_2(smp_2), .smp_3(smp_3),
    .pair_sel(pair_sel), .bipolar_en(bipolar_en), .gain_x2(gain_x2),
    .inc_o(inc_f)
  );

  vfc_delay #(.ACC_W(ACC_W), .STAGES(SETTLE_CYC), .RESET_CODE(SPAN)) u_delay (
    .clk(clk), .rst_n(rst_n), .d_i(inc_f), .q_o(inc_d)
  );

  vfc_loop #(.ACC_W(ACC_W), .QUANTUM(QUANTUM), .SETTLE_CYC(SETTLE_CYC)) u_loop (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .inc_i(inc_d), .pulse_o(pulse_o)
  );

  // R7: power-down silences the output from the next edge
  p_pd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !pulse_o);
endmodule

// File: tb/tb_vfc_pulse_mod.sv
module tb_vfc_pulse_mod;
  localparam int SMP_W = 12, REF_CODE = 2048, ACC_W = 24, SETTLE_CYC = 2;
  localparam longint SPAN = 2 * REF_CODE;
  localparam longint QNT  = 20 * SPAN;

  logic clk = 1'b0, rst_n = 1'b0, pd_n = 1'b1;
  logic [SMP_W-1:0] s0 = '0, s1 = '0, s2 = '0, s3 = '0;
  logic [1:0] sel = 2'b00;
  logic bip = 1'b0, g2 = 1'b0;
  logic pulse;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  vfc_pulse_mod #(.SMP_W(SMP_W), .REF_CODE(REF_CODE), .ACC_W(ACC_W),
                  .SETTLE_CYC(SETTLE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
    .smp_0(s0), .smp_1(s1), .smp_2(s2), .smp_3(s3),
    .pair_sel(sel), .bipolar_en(bip), .gain_x2(g2), .pulse_o(pulse));

  always #10 clk = ~clk;

  // Expected rate increment (per QNT) from R4, R5, R6: rate = (1+8p)/20
  function automatic longint exp_inc(int a, int b, int c, int d, int ps, bit bp, bit gx);
    longint pos, neg, sc, p2;
    case (ps)
      0: begin pos = a; neg = d; end
      1: begin pos = b; neg = d; end
      2: begin pos = c; neg = d; end
      default: begin pos = a; neg = b; end
    endcase
    sc = (pos - neg) * (gx ? 2 : 1);
    p2 = bp ? sc + REF_CODE : 2 * sc;
    if (p2 < 0) p2 = 0;
    if (p2 > SPAN) p2 = SPAN;
    return SPAN + 8 * p2;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R1/R3: count over n clocks, check rate and single-clock width
  task automatic rate_check(int n, string req);
    longint inc, cnt;
    bit prev, b2b;
    inc = exp_inc(s0, s1, s2, s3, sel, bip, g2);
    repeat (8) @(negedge clk);
    cnt = 0; prev = 0; b2b = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pulse) cnt++;
      if (pulse && prev) b2b = 1;
      prev = pulse;
    end
    check((cnt * QNT - n * inc < QNT) && (n * inc - cnt * QNT < QNT),
          req, cnt, (n * inc) / QNT);
    check(!b2b, "R3 back-to-back", b2b, 0);
  endtask

  // R2: spacing between pulses stays within [lo,hi]
  task automatic spacing_check(int lo, int hi, string req);
    int last, bad;
    repeat (8) @(negedge clk);
    last = -1; bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pulse) begin
        if (last >= 0 && (i - last < lo || i - last > hi)) bad = i - last;
        last = i;
      end
    end
    check(bad == 0 && last >= 0, req, bad, lo);
  endtask

  task automatic set_in(int a, int b, int c, int d, int ps, bit bp, bit gx);
    s0 = SMP_W'(a); s1 = SMP_W'(b); s2 = SMP_W'(c); s3 = SMP_W'(d);
    sel = 2'(ps); bip = bp; g2 = gx;
  endtask

  initial begin
    int seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(pulse == 1'b0, "R9 reset output", pulse, 0);
    rst_n = 1'b1;

    // R2 cadences, unipolar gain 1 on pair 0-3
    set_in(1524, 0, 0, 500, 0, 0, 0); spacing_check(4, 4, "R2 half scale every 4");
    set_in(756, 0, 0, 500, 0, 0, 0);  spacing_check(10, 10, "R2 eighth scale every 10");
    set_in(1012, 0, 0, 500, 0, 0, 0); spacing_check(6, 7, "R2 quarter scale 6/7");

    // R1 end points
    set_in(500, 0, 0, 500, 0, 0, 0);  rate_check(2000, "R1 zero scale");
    set_in(2548, 0, 0, 500, 0, 0, 0); rate_check(2000, "R1 full scale");
    // R4 each pair at half scale in unipolar
    set_in(0, 1124, 0, 100, 1, 0, 0); spacing_check(4, 4, "R4 pair 1-3");
    set_in(0, 0, 1124, 100, 2, 0, 0); spacing_check(4, 4, "R4 pair 2-3");
    set_in(1124, 100, 4000, 4000, 3, 0, 0); spacing_check(4, 4, "R4 pair 0-1");
    // R5 bipolar zero difference is mid rate; gain 2 halves the span
    set_in(3000, 0, 0, 3000, 0, 1, 1); spacing_check(4, 4, "R5 bipolar zero");
    set_in(1012, 0, 0, 500, 0, 0, 1); spacing_check(4, 4, "R5 gain2 quarter->half");
    // R6 saturation
    set_in(100, 0, 0, 4000, 0, 1, 0); rate_check(2000, "R6 low clamp");
    set_in(4000, 0, 0, 0, 0, 0, 1);   rate_check(2000, "R6 high clamp");

    // R7 power-down, R8 settle after release
    set_in(2548, 0, 0, 500, 0, 0, 0);
    repeat (10) @(negedge clk);
    pd_n = 1'b0;
    seen = 0;
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pulse) seen++; end
    check(seen == 0, "R7 power-down quiet", seen, 0);
    pd_n = 1'b1;
    seen = 0;
    for (int i = 0; i < SETTLE_CYC; i++) begin @(negedge clk); if (pulse) seen++; end
    check(seen == 0, "R8 settle quiet", seen, 0);
    rate_check(1000, "R8 resumes");

    // R1/R4/R5/R6 random points
    for (int k = 0; k < 22; k++) begin
      set_in($urandom % 4096, $urandom % 4096, $urandom % 4096, $urandom % 4096,
             $urandom % 4, $urandom % 2, $urandom % 2);
      rate_check(2048, "R1 random");
    end

    // R9 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check(pulse == 1'b0, "R9 reset mid-run", pulse, 0);
    rst_n = 1'b1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule